// File: doc/BRIEF.md
# Raster line interrupt counter

This block raises a periodic interrupt that is locked to the video timing. It counts transitions of the horizontal sync line, both rising and falling. A source select can make it count every cycle of the system clock instead. When a programmed number of events has been counted, the block emits a one-cycle terminal pulse, sets a level interrupt request and reloads itself so that counting carries on. Any change of level on a trigger input derived from vertical sync restarts the count, which keeps the interrupts in phase with the frame.

Software uses a small write port with two registers. Address 0 holds a 16-bit reload value. Address 1 is a mode register: bit 0 picks the count source, and writing a 1 to bit 4 clears the pending interrupt. Clearing the interrupt never touches the running count, so the interrupt spacing stays regular even when the handler responds late. Both asynchronous inputs pass through two-flop synchronisers. An input transition therefore reaches the outputs on the third rising clock edge after it is sampled.

Top module: `rli_top`

## Requirements
- R1: After reset, irq_o and tc_o are low, the reload value is 26 and the counter is loaded with 26, so 25 count events leave irq_o low and the 26th sets it.
- R2: In source mode 0, every transition of hsync_i is one count event, whether it rises or falls.
- R3: An event that completes the count drives tc_o high for exactly one cycle and sets irq_o. Both appear on the third rising clock edge after the input transition is first sampled.
- R4: After a terminal count the counter reloads by itself, and the next terminal count follows after another reload-value events.
- R5: Every transition of trig_i, rising or falling, reloads the counter from the reload value. A restart produces no terminal pulse.
- R6: When a trigger event and a count event fall in the same cycle, the restart takes effect and the count event is discarded.
- R7: A write to address 1 with bit 4 set clears irq_o on the next clock edge and does not change the counter.
- R8: When a terminal count and a clear write fall in the same cycle, irq_o stays set.
- R9: A write to address 0 stores a new reload value. The value takes effect only at the next automatic reload or restart, and the count in progress is left alone.
- R10: Every write to address 1 stores bit 0 as the count source. Value 1 counts every clock cycle and ignores hsync_i, so with reload value N the terminal pulses come N cycles apart.
- R11: Writes to addresses 2 and 3 change neither the reload value, the source, nor irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Asynchronous horizontal sync; both edges count |
| trig_i | input | 1 | Asynchronous restart trigger; both edges restart |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 reload, 1 mode |
| wr_data_i | input | 16 | Write data |
| irq_o | output | 1 | Level interrupt request |
| tc_o | output | 1 | One-cycle terminal count pulse |

## Verification
The bench drives a trigger edge and a count edge into the same cycle. A design that let the count through would fire one event early and shift every later interrupt. It places a clear write in the same cycle as a terminal count, where a wrong priority would lose an interrupt. It clears in the middle of a count to catch a design that reloads the counter on a clear. It writes a new reload value while a count is in progress, which exposes a design that applies the value at once. It also toggles hsync_i while in clock-count mode and confirms the period stays at the reload value. Finally, it writes to the unused addresses to catch decoding that folds them onto the real registers.

// File: rtl/rli_pkg.sv
package rli_pkg;

    localparam int CNT_W        = 16;
    localparam int ADDR_W       = 2;
    localparam int DATA_W       = 16;
    localparam int SYNC_STAGES  = 2;
    localparam logic [CNT_W-1:0] RELOAD_DEFAULT = CNT_W'(26);

    localparam logic [ADDR_W-1:0] ADDR_RELOAD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_MODE   = ADDR_W'(1);

    localparam int MODE_SRC_BIT = 0;
    localparam int MODE_CLR_BIT = 4;

    typedef enum logic {
        SRC_HSYNC = 1'b0,
        SRC_CLOCK = 1'b1
    } count_src_e;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        count_src_e       src;
        logic             clr;
    } ctrl_t;

    typedef struct packed {
        logic count;
        logic restart;
    } evt_t;

    function automatic logic is_last(input logic [CNT_W-1:0] value);
        return value <= CNT_W'(1);
    endfunction

endpackage

// File: rtl/rli_sync_edge.sv
module rli_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[LAST-1:0], async_i};
        end
    end

    assign edge_o = pipe_q[LAST-1] ^ pipe_q[LAST];

endmodule

// File: rtl/rli_regs.sv
module rli_regs
    import rli_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output ctrl_t             ctrl_o
);
    logic [CNT_W-1:0] reload_q;
    count_src_e       src_q;
    logic             hit_reload;
    logic             hit_mode;

    assign hit_reload = wr_en_i && (wr_addr_i == ADDR_RELOAD);
    assign hit_mode   = wr_en_i && (wr_addr_i == ADDR_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= RELOAD_DEFAULT;
            src_q    <= SRC_HSYNC;
        end else begin
            if (hit_reload) begin
                reload_q <= wr_data_i[CNT_W-1:0];
            end
            if (hit_mode) begin
                src_q <= count_src_e'(wr_data_i[MODE_SRC_BIT]);
            end
        end
    end

    assign ctrl_o.reload = reload_q;
    assign ctrl_o.src    = src_q;
    assign ctrl_o.clr    = hit_mode && wr_data_i[MODE_CLR_BIT];

    a_r9_reload_store: assert property (@(posedge clk) disable iff (rst)
        hit_reload |=> (reload_q == $past(wr_data_i[CNT_W-1:0])));

    a_r11_other_addr: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i != ADDR_RELOAD && wr_addr_i != ADDR_MODE)
        |=> ($stable(reload_q) && $stable(src_q)));

endmodule

// File: rtl/rli_counter.sv
module rli_counter
    import rli_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             hit_o,
    output logic             tc_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step  = evt_i.count && !evt_i.restart;
    assign hit_o = step && is_last(cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RELOAD_DEFAULT;
            tc_o  <= 1'b0;
        end else begin
            tc_o <= hit_o;
            if (evt_i.restart) begin
                cnt_q <= reload_i;
            end else if (step) begin
                if (is_last(cnt_q)) begin
                    cnt_q <= reload_i;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    a_r5_restart_loads: assert property (@(posedge clk) disable iff (rst)
        evt_i.restart |=> (cnt_q == $past(reload_i)));

    a_r6_restart_wins: assert property (@(posedge clk) disable iff (rst)
        (evt_i.restart && evt_i.count) |=> !tc_o);

    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (evt_i.count && !evt_i.restart && cnt_q > CNT_W'(1))
        |=> ((cnt_q == $past(cnt_q) - CNT_W'(1)) && !tc_o));

    a_r4_auto_reload: assert property (@(posedge clk) disable iff (rst)
        tc_o |-> (cnt_q == $past(reload_i)));

endmodule

// File: rtl/rli_irq.sv
module rli_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
        end else if (set_i) begin
            irq_o <= 1'b1;
        end else if (clr_i) begin
            irq_o <= 1'b0;
        end
    end

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (set_i && clr_i) |=> irq_o);

    a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !irq_o);

endmodule

// File: rtl/rli_top.sv
module rli_top
    import rli_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hsync_i,
    input  logic        trig_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_addr_i,
    input  logic [15:0] wr_data_i,
    output logic        irq_o,
    output logic        tc_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] async_in;
    logic [N_IN-1:0] in_edge;
    ctrl_t           ctrl;
    evt_t            evt;
    logic            hit;

    assign async_in = {trig_i, hsync_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        rli_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (async_in[g]),
            .edge_o  (in_edge[g])
        );
    end

    rli_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ctrl_o    (ctrl)
    );

    assign evt.restart = in_edge[1];
    assign evt.count   = (ctrl.src == SRC_CLOCK) ? 1'b1 : in_edge[0];

    rli_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .reload_i (ctrl.reload),
        .hit_o    (hit),
        .tc_o     (tc_o)
    );

    rli_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .set_i (hit),
        .clr_i (ctrl.clr),
        .irq_o (irq_o)
    );

    a_r3_pulse_sets_irq: assert property (@(posedge clk) disable iff (rst)
        tc_o |-> irq_o);

    a_r3_irq_rise_has_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> tc_o);

endmodule

// File: tb/rli_top_tb_top.sv
module rli_top_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync_i = 1'b0;
    logic        trig_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = 2'd0;
    logic [15:0] wr_data_i = 16'd0;
    logic        irq_o;
    logic        tc_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rli_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .hsync_i   (hsync_i),
        .trig_i    (trig_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .irq_o     (irq_o),
        .tc_o      (tc_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic hs_edges(input int n);
        for (int i = 0; i < n; i++) begin
            hsync_i = ~hsync_i;
            settle();
        end
    endtask

    task automatic trig_edge();
        trig_i = ~trig_i;
        settle();
    endtask

    task automatic reg_write(input logic [1:0] addr, input logic [15:0] data);
        wr_en_i   = 1'b1;
        wr_addr_i = addr;
        wr_data_i = data;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic clear_irq();
        reg_write(2'd1, 16'h0010);
        check(irq_o == 1'b0, "R7 clear", irq_o, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
        check(tc_o == 1'b0, "R1 tc after reset", tc_o, 0);
        hs_edges(25);
        check(irq_o == 1'b0, "R1 R2 25 transitions", irq_o, 0);
        hs_edges(1);
        check(irq_o == 1'b1, "R1 R2 26th transition", irq_o, 1);
        check(tc_o == 1'b1, "R3 pulse high", tc_o, 1);
        @(negedge clk);
        check(tc_o == 1'b0, "R3 pulse one cycle", tc_o, 0);
        check(irq_o == 1'b1, "R3 irq level held", irq_o, 1);
    endtask

    task automatic t_clear_mid_count();
        hs_edges(10);
        clear_irq();
        hs_edges(15);
        check(irq_o == 1'b0, "R4 R7 before terminal", irq_o, 0);
        hs_edges(1);
        check(irq_o == 1'b1, "R4 R7 count kept across clear", irq_o, 1);
    endtask

    task automatic t_unused_addr();
        reg_write(2'd3, 16'h0011);
        reg_write(2'd2, 16'h0003);
        @(negedge clk);
        check(irq_o == 1'b1, "R11 irq untouched", irq_o, 1);
        clear_irq();
        trig_edge();
        hs_edges(25);
        check(irq_o == 1'b0, "R11 reload and source unchanged", irq_o, 0);
        hs_edges(1);
        check(irq_o == 1'b1, "R11 terminal at 26", irq_o, 1);
    endtask

    task automatic t_restart();
        clear_irq();
        hs_edges(10);
        trig_edge();
        check(tc_o == 1'b0, "R5 no pulse on restart", tc_o, 0);
        hs_edges(25);
        check(irq_o == 1'b0, "R5 restart reloads", irq_o, 0);
        hs_edges(1);
        check(irq_o == 1'b1, "R5 terminal after restart", irq_o, 1);
    endtask

    task automatic t_coincide();
        clear_irq();
        hs_edges(25);
        hsync_i = ~hsync_i;
        trig_i  = ~trig_i;
        settle();
        check(irq_o == 1'b0, "R6 count dropped on restart", irq_o, 0);
        hs_edges(25);
        check(irq_o == 1'b0, "R6 full count after restart", irq_o, 0);
        hs_edges(1);
        check(irq_o == 1'b1, "R6 terminal", irq_o, 1);
    endtask

    task automatic t_clear_collision();
        clear_irq();
        trig_edge();
        hs_edges(25);
        hsync_i = ~hsync_i;
        @(negedge clk);
        @(negedge clk);
        reg_write(2'd1, 16'h0010);
        check(tc_o == 1'b1, "R8 terminal cycle", tc_o, 1);
        check(irq_o == 1'b1, "R8 set wins over clear", irq_o, 1);
        @(negedge clk);
        check(irq_o == 1'b1, "R8 irq held", irq_o, 1);
    endtask

    task automatic t_reload_write();
        clear_irq();
        reg_write(2'd0, 16'd4);
        hs_edges(25);
        check(irq_o == 1'b0, "R9 new reload not applied early", irq_o, 0);
        hs_edges(1);
        check(irq_o == 1'b1, "R9 old count finished", irq_o, 1);
        clear_irq();
        hs_edges(3);
        check(irq_o == 1'b0, "R9 three of four", irq_o, 0);
        hs_edges(1);
        check(irq_o == 1'b1, "R9 new reload used", irq_o, 1);
    endtask

    task automatic t_clock_source();
        bit found = 1'b0;
        int n = 0;
        reg_write(2'd0, 16'd5);
        reg_write(2'd1, 16'h0001);
        for (int i = 0; i < 20 && !found; i++) begin
            @(negedge clk);
            found = tc_o;
        end
        check(found, "R10 pulse in clock mode", int'(found), 1);
        do begin
            hsync_i = ~hsync_i;
            @(negedge clk);
            n++;
        end while (!tc_o && n < 20);
        check(n == 5, "R10 period equals reload", n, 5);
        check(irq_o == 1'b1, "R10 irq set", irq_o, 1);
        reg_write(2'd1, 16'h0010);
    endtask

    initial begin
        t_reset();
        t_clear_mid_count();
        t_unused_addr();
        t_restart();
        t_coincide();
        t_clear_collision();
        t_reload_write();
        t_clock_source();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule